// File: doc/BRIEF.md
# DS3 Transmit Overhead Inserter

This block produces a serial DS3 stream by interleaving framing overhead with a payload that arrives one bit per request. A free-running position counter walks the M-frame: seven subframes, each made of eight blocks, each block one overhead bit followed by `PAY_BITS` payload bits (84 in the standard format, so 4760 bits per frame). On every payload position the block raises a request and samples the payload input in that same cycle. On overhead positions it emits the bit that belongs there instead.

The first overhead bit of each subframe carries the remote-failure bits (subframes 1 and 2), the parity bits (subframes 3 and 4) or the multiframe alignment bits (subframes 5 to 7). The odd blocks carry the subframe alignment bits, and the remaining three positions of each subframe carry C-bits. In C-bit parity mode the C-bits are generated internally: an identifier, a network-requirement bit, a far-end alarm channel bit, path-parity copies, far-end block error bits, data link bits and filler ones. The far-end alarm and data link bits are pulled from serial inputs, each with its own take strobe. In M23 mode all C-bits of a subframe repeat an externally supplied stuff indication. Five one-shot diagnostic controls corrupt a single occurrence of five separate overhead channels.

Top module: `ds3_ovh_insert`

## Requirements
- R1: One frame is 7 subframes × 8 blocks × (`PAY_BITS`+1) bits. Each block begins with one overhead bit. Within a subframe the overhead order is lead, F1, C1, F2, C2, F3, C3, F4. `tx_fs` is high exactly in the cycle when `tx_data` carries the lead bit of subframe 1.
- R2: `pay_req` is high in the cycle of every payload position and low otherwise. The `pay_bit` value sampled in that cycle appears on `tx_data` one clock later.
- R3: The F-bits F1..F4 of every subframe are 1,0,0,1. The lead bits of subframes 5, 6 and 7 are 0, 1, 0.
- R4: Both lead bits of subframes 1 and 2 equal the inverse of `rfail` as sampled at the subframe-1 lead position. They are 0 while failure is signalled and 1 otherwise.
- R5: Both lead bits of subframes 3 and 4 equal the modulo-2 sum of all payload bits of the previous frame. In the first frame after reset they are 0.
- R6: With `cbp_mode`=1, the C-bits of subframe 1 are: C1 = 1, C2 = `nr_bit`, and C3 = `feac_bit`. `feac_take` is high in the cycle that C3 position is sampled. All C-bits of subframes 2, 6 and 7 are 1.
- R7: With `cbp_mode`=1, all three C-bits of subframe 3 equal the parity value sent in the subframe-3 and subframe-4 lead bits.
- R8: With `cbp_mode`=1, the three C-bits of subframe 4 are 0 while `febe_ind`=1 and 1 while it is 0.
- R9: With `cbp_mode`=1, the three C-bits of subframe 5 carry `dl_bit`. `dl_take` is high in each cycle where one of them is sampled.
- R10: With `cbp_mode`=0, every C-bit of subframe s (1..7) equals `stuff_ind[s-1]`, and `feac_take` and `dl_take` stay low.
- R11: A rising edge of `force_f`, `force_m`, `force_p` or `force_cp` inverts only the next F-bit, multiframe bit, parity lead bit or CP-bit respectively. A rising edge of `force_febe` drives only the next far-end block error bit to 0. Holding a control high has no further effect.
- R12: While `rst_n` is low, `tx_data`, `tx_fs` and `pay_req` are 0. The first bit sent after release is the subframe-1 lead bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one output bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cbp_mode | input | 1 | 1 = C-bit parity layout, 0 = M23 stuff-control layout |
| rfail | input | 1 | Remote failure indication for the X positions |
| nr_bit | input | 1 | Network requirement bit value |
| febe_ind | input | 1 | Far-end block error indication |
| stuff_ind | input | 7 | Per-subframe stuff indication used in M23 mode |
| force_f | input | 1 | Invert the next F-bit (on rising edge) |
| force_m | input | 1 | Invert the next multiframe bit (on rising edge) |
| force_p | input | 1 | Invert the next parity lead bit (on rising edge) |
| force_cp | input | 1 | Invert the next CP-bit (on rising edge) |
| force_febe | input | 1 | Zero the next far-end block error bit (on rising edge) |
| pay_req | output | 1 | Payload bit requested this cycle |
| pay_bit | input | 1 | Payload bit, sampled while `pay_req` is high |
| feac_take | output | 1 | Far-end alarm channel bit sampled this cycle |
| feac_bit | input | 1 | Far-end alarm channel serial bit |
| dl_take | output | 1 | Data link bit sampled this cycle |
| dl_bit | input | 1 | Data link serial bit |
| tx_data | output | 1 | Serial output stream |
| tx_fs | output | 1 | Marks the first bit of each frame on `tx_data` |

## Verification
The embedded properties watch, on every clock, the following:
- payload bits pass through with one cycle of delay;
- the frame counter wraps from the last position to the first;
- the parity register changes only at frame ends;
- the identifier is 1 in parity mode;
- the X-bit is zero while failure is signalled;
- CP-bits follow the stored parity;
- each diagnostic pending flag clears at its first use and is never re-armed by a held control.

Only the directed scenarios can confirm the bit-exact content of every position against an independent frame model. Those scenarios cover the alignment patterns, the parity of real payload, the switch between C-bit layouts, and that a long-held force control inverts exactly one F-bit across two frames.

// File: rtl/ds3_ovh_pkg.sv
package ds3_ovh_pkg;

   localparam int SUBFRAMES = 7;
   localparam int BLOCKS    = 8;
   localparam int SF_W      = $clog2(SUBFRAMES);
   localparam int BLK_W     = $clog2(BLOCKS);

   // diagnostic channels, index into the force bank
   typedef enum logic [2:0] {
      FC_F    = 3'd0,
      FC_M    = 3'd1,
      FC_P    = 3'd2,
      FC_CP   = 3'd3,
      FC_FEBE = 3'd4
   } force_ch_e;
   localparam int NFORCE = 5;

   typedef struct packed {
      logic [SF_W-1:0]  sf;
      logic [BLK_W-1:0] blk;
      logic             ovh;
      logic             first;
      logic             last;
   } slot_t;

endpackage

// File: rtl/ds3_ovh_timing.sv
module ds3_ovh_timing
   import ds3_ovh_pkg::*;
#(
   parameter int PAY_BITS = 84
) (
   input  logic  clk,
   input  logic  rst_n,
   output slot_t slot
);
   localparam int BLK_LEN = PAY_BITS + 1;
   localparam int PW      = $clog2(BLK_LEN);
   localparam logic [PW-1:0]    POS_MAX = PW'(BLK_LEN - 1);
   localparam logic [BLK_W-1:0] BLK_MAX = BLK_W'(BLOCKS - 1);
   localparam logic [SF_W-1:0]  SF_MAX  = SF_W'(SUBFRAMES - 1);

   logic [PW-1:0]    pos;
   logic [BLK_W-1:0] blk;
   logic [SF_W-1:0]  sf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos <= '0;
         blk <= '0;
         sf  <= '0;
      end else if (pos == POS_MAX) begin
         pos <= '0;
         if (blk == BLK_MAX) begin
            blk <= '0;
            sf  <= (sf == SF_MAX) ? '0 : sf + 1'b1;
         end else begin
            blk <= blk + 1'b1;
         end
      end else begin
         pos <= pos + 1'b1;
      end
   end

   always_comb begin
      slot.sf    = sf;
      slot.blk   = blk;
      slot.ovh   = (pos == '0);
      slot.first = (pos == '0) && (blk == '0) && (sf == '0);
      slot.last  = (pos == POS_MAX) && (blk == BLK_MAX) && (sf == SF_MAX);
   end

   AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      slot.last |=> slot.first) else $error("frame did not wrap"); // R1

endmodule

// File: rtl/ds3_ovh_force.sv
module ds3_ovh_force #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   input  logic [N-1:0] use_slot,
   output logic [N-1:0] pend
);
   for (genvar i = 0; i < N; i++) begin : g_ch
      logic req_q;
      logic armed;
      logic rise;

      assign rise = req[i] && !req_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q <= 1'b0;
            armed <= 1'b0;
         end else begin
            req_q <= req[i];
            if (rise)             armed <= 1'b1;
            else if (use_slot[i]) armed <= 1'b0;
         end
      end

      assign pend[i] = armed;

      AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && use_slot[i] && !rise) |=> !armed) else $error("force stayed armed"); // R11
      AST_HELD_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
         (req[i] && req_q && !armed) |=> !armed) else $error("held force re-armed"); // R11
   end
endmodule

// File: rtl/ds3_ovh_parity.sv
module ds3_ovh_parity (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic bit_in,
   input  logic frame_end,
   output logic par_prev
);
   logic acc;
   logic acc_nxt;

   assign acc_nxt = acc ^ (take & bit_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc      <= 1'b0;
         par_prev <= 1'b0;
      end else if (frame_end) begin
         acc      <= 1'b0;
         par_prev <= acc_nxt;
      end else begin
         acc      <= acc_nxt;
      end
   end

   AST_PAR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_end |=> $stable(par_prev)) else $error("parity moved mid-frame"); // R5

endmodule

// File: rtl/ds3_ovh_insert.sv
module ds3_ovh_insert
   import ds3_ovh_pkg::*;
#(
   parameter int PAY_BITS = 84
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cbp_mode,
   input  logic       rfail,
   input  logic       nr_bit,
   input  logic       febe_ind,
   input  logic [6:0] stuff_ind,
   input  logic       force_f,
   input  logic       force_m,
   input  logic       force_p,
   input  logic       force_cp,
   input  logic       force_febe,
   output logic       pay_req,
   input  logic       pay_bit,
   output logic       feac_take,
   input  logic       feac_bit,
   output logic       dl_take,
   input  logic       dl_bit,
   output logic       tx_data,
   output logic       tx_fs
);
   slot_t slot;

   ds3_ovh_timing #(.PAY_BITS(PAY_BITS)) u_tim (
      .clk   (clk),
      .rst_n (rst_n),
      .slot  (slot)
   );

   // position decode
   logic       is_lead, is_f, is_c;
   logic       lead_x, lead_p, lead_m;
   logic       c_cp, c_febe;
   logic [1:0] cidx;

   always_comb begin
      is_lead = slot.ovh && (slot.blk == '0);
      is_f    = slot.ovh && slot.blk[0];
      is_c    = slot.ovh && !slot.blk[0] && (slot.blk != '0);
      cidx    = slot.blk[2:1] - 2'd1;
      lead_x  = is_lead && (slot.sf < 3'd2);
      lead_p  = is_lead && ((slot.sf == 3'd2) || (slot.sf == 3'd3));
      lead_m  = is_lead && (slot.sf >= 3'd4);
      c_cp    = is_c && cbp_mode && (slot.sf == 3'd2);
      c_febe  = is_c && cbp_mode && (slot.sf == 3'd3);
   end

   assign pay_req   = !slot.ovh;
   assign feac_take = is_c && cbp_mode && (slot.sf == 3'd0) && (cidx == 2'd2);
   assign dl_take   = is_c && cbp_mode && (slot.sf == 3'd4);

   // diagnostic one-shots
   logic [NFORCE-1:0] frc_req, frc_use, frc_pend, inv;

   always_comb begin
      frc_req          = '0;
      frc_use          = '0;
      frc_req[FC_F]    = force_f;
      frc_req[FC_M]    = force_m;
      frc_req[FC_P]    = force_p;
      frc_req[FC_CP]   = force_cp;
      frc_req[FC_FEBE] = force_febe;
      frc_use[FC_F]    = is_f;
      frc_use[FC_M]    = lead_m;
      frc_use[FC_P]    = lead_p;
      frc_use[FC_CP]   = c_cp;
      frc_use[FC_FEBE] = c_febe;
   end

   ds3_ovh_force #(.N(NFORCE)) u_frc (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (frc_req),
      .use_slot (frc_use),
      .pend     (frc_pend)
   );

   assign inv = frc_pend & frc_use;

   // previous-frame parity
   logic par_prev;

   ds3_ovh_parity u_par (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (pay_req),
      .bit_in    (pay_bit),
      .frame_end (slot.last),
      .par_prev  (par_prev)
   );

   // X value held from subframe 1 for subframe 2
   logic x_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           x_hold <= 1'b1;
      else if (lead_x && slot.sf == 3'd0)   x_hold <= ~rfail;
   end

   // C-bit content for the two layouts
   logic c_val;

   always_comb begin
      if (cbp_mode) begin
         case (slot.sf)
            3'd0: begin
               case (cidx)
                  2'd0:    c_val = 1'b1;
                  2'd1:    c_val = nr_bit;
                  default: c_val = feac_bit;
               endcase
            end
            3'd2:    c_val = par_prev ^ inv[FC_CP];
            3'd3:    c_val = ~febe_ind & ~inv[FC_FEBE];
            3'd4:    c_val = dl_bit;
            default: c_val = 1'b1;
         endcase
      end else begin
         c_val = stuff_ind[slot.sf];
      end
   end

   logic bit_nxt;

   always_comb begin
      if (!slot.ovh)      bit_nxt = pay_bit;
      else if (lead_x)    bit_nxt = (slot.sf == 3'd0) ? ~rfail : x_hold;
      else if (lead_p)    bit_nxt = par_prev ^ inv[FC_P];
      else if (lead_m)    bit_nxt = (slot.sf == 3'd5) ^ inv[FC_M];
      else if (is_f)      bit_nxt = ((slot.blk == 3'd1) || (slot.blk == 3'd7)) ^ inv[FC_F];
      else                bit_nxt = c_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_data <= 1'b0;
         tx_fs   <= 1'b0;
      end else begin
         tx_data <= bit_nxt;
         tx_fs   <= slot.first;
      end
   end

   AST_PAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      pay_req |=> (tx_data == $past(pay_bit))) else $error("payload not passed"); // R2
   AST_AIC_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (cbp_mode && is_c && slot.sf == 3'd0 && cidx == 2'd0) |=> tx_data) else $error("identifier not one"); // R6
   AST_CP_TRACKS_P: assert property (@(posedge clk) disable iff (!rst_n)
      (c_cp && !frc_pend[FC_CP]) |=> (tx_data == $past(par_prev))) else $error("CP mismatch"); // R7
   AST_X_FAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_x && slot.sf == 3'd0 && rfail) |=> !tx_data) else $error("X not zero"); // R4

endmodule

// File: tb/ds3_ovh_insert_test.sv
`timescale 1ns/1ps
module ds3_ovh_insert_test;
   localparam int PAY   = 84;
   localparam int BLEN  = PAY + 1;
   localparam int SFLEN = 8 * BLEN;
   localparam int FRAME = 7 * SFLEN;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cbp_mode = 1'b1, rfail = 1'b0, nr_bit = 1'b0, febe_ind = 1'b0;
   logic [6:0] stuff_ind = '0;
   logic force_f = 0, force_m = 0, force_p = 0, force_cp = 0, force_febe = 0;
   logic pay_bit = 0, feac_bit = 0, dl_bit = 0;
   logic pay_req, feac_take, dl_take, tx_data, tx_fs;

   always #5 clk = ~clk;

   ds3_ovh_insert #(.PAY_BITS(PAY)) uut (
      .clk(clk), .rst_n(rst_n), .cbp_mode(cbp_mode), .rfail(rfail),
      .nr_bit(nr_bit), .febe_ind(febe_ind), .stuff_ind(stuff_ind),
      .force_f(force_f), .force_m(force_m), .force_p(force_p),
      .force_cp(force_cp), .force_febe(force_febe),
      .pay_req(pay_req), .pay_bit(pay_bit), .feac_take(feac_take),
      .feac_bit(feac_bit), .dl_take(dl_take), .dl_bit(dl_bit),
      .tx_data(tx_data), .tx_fs(tx_fs)
   );

   int errors = 0;
   int nchk = 0;
   bit done = 0;

   // bench frame model state
   int k = 0;
   bit have_prev = 0;
   bit prev_exp, prev_fs, prev_isf, prev_fnom;
   string prev_tag;
   bit acc = 0, bprev = 0, xh = 1;
   bit [4:0] bpend = '0, fprev = '0;
   logic [15:0] lfsr = 16'hACE1;
   int fdev = 0;

   task automatic chk(input string tag, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%b expected=%b (slot %0d)", tag, act, exp, k);
      end
   endtask

   task automatic model_reset();
      k = 0; have_prev = 0; acc = 0; bprev = 0; xh = 1;
      bpend = '0; fprev = '0;
   endtask

   // one bit time: check previous output, drive and predict this slot
   task automatic drive_slot();
      int fk, sfi, r, bl, ps, ci;
      bit e, ep, ef, ed, isf, fnom;
      bit [4:0] usev, fcur;
      string tg;
      if (have_prev) begin
         chk(prev_tag, tx_data, prev_exp);
         chk("R1 frame start", tx_fs, prev_fs);
         if (prev_isf && (tx_data != prev_fnom)) fdev++;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pay_bit  = lfsr[0];
      feac_bit = lfsr[5];
      dl_bit   = lfsr[9];
      fk  = k % FRAME;
      sfi = fk / SFLEN;
      r   = fk % SFLEN;
      bl  = r / BLEN;
      ps  = r % BLEN;
      ep = 0; ef = 0; ed = 0; isf = 0; fnom = 0; usev = '0;
      if (ps != 0) begin
         e = pay_bit; tg = "R2 payload"; ep = 1;
      end else if (bl == 0) begin
         if (sfi < 2) begin
            e = (sfi == 0) ? ~rfail : xh; tg = "R4 X-bit";
         end else if (sfi < 4) begin
            e = bprev ^ bpend[2]; tg = "R5/R11 P-bit"; usev[2] = 1;
         end else begin
            e = (sfi == 5) ^ bpend[1]; tg = "R3/R11 M-bit"; usev[1] = 1;
         end
      end else if (bl % 2 == 1) begin
         fnom = (bl == 1 || bl == 7); isf = 1;
         e = fnom ^ bpend[0]; tg = "R3/R11 F-bit"; usev[0] = 1;
      end else begin
         ci = bl / 2 - 1;
         if (cbp_mode) begin
            case (sfi)
               0: begin
                  if (ci == 0)      begin e = 1;        tg = "R6 AIC"; end
                  else if (ci == 1) begin e = nr_bit;   tg = "R6 NR";  end
                  else              begin e = feac_bit; tg = "R6 FEAC"; ef = 1; end
               end
               2: begin e = bprev ^ bpend[3]; tg = "R7/R11 CP-bit"; usev[3] = 1; end
               3: begin e = ~febe_ind & ~bpend[4]; tg = "R8/R11 FEBE"; usev[4] = 1; end
               4: begin e = dl_bit; tg = "R9 DL"; ed = 1; end
               default: begin e = 1; tg = "R6 filler"; end
            endcase
         end else begin
            e = stuff_ind[sfi]; tg = "R10 M23 C-bit";
         end
      end
      #1;
      chk("R2 pay_req", pay_req, ep);
      chk(cbp_mode ? "R6 feac_take" : "R10 feac_take", feac_take, ef);
      chk(cbp_mode ? "R9 dl_take" : "R10 dl_take", dl_take, ed);
      // model updates after this slot
      if (ep) acc ^= pay_bit;
      if (fk == FRAME - 1) begin bprev = acc; acc = 0; end
      if (sfi == 0 && ps == 0 && bl == 0) xh = ~rfail;
      fcur = {force_febe, force_cp, force_p, force_m, force_f};
      for (int i = 0; i < 5; i++) begin
         if (fcur[i] && !fprev[i]) bpend[i] = 1;
         else if (usev[i])         bpend[i] = 0;
      end
      fprev = fcur;
      prev_exp = e; prev_tag = tg; prev_fs = (fk == 0);
      prev_isf = isf; prev_fnom = fnom;
      have_prev = 1;
      k++;
      @(negedge clk);
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) drive_slot();
   endtask

   task automatic t_reset();
      rst_n = 0;
      repeat (4) @(negedge clk);
      chk("R12 tx_data in reset", tx_data, 1'b0);
      chk("R12 tx_fs in reset", tx_fs, 1'b0);
      chk("R12 pay_req in reset", pay_req, 1'b0);
      model_reset();
      rst_n = 1;
      drive_slot();
      chk("R12 first bit is frame start", tx_fs, 1'b1);
   endtask

   task automatic t_cbp();
      cbp_mode = 1; rfail = 0; nr_bit = 1; febe_ind = 0;
      run(FRAME - 1);
      rfail = 1; nr_bit = 0;
      run(2 * FRAME);
      rfail = 0;
   endtask

   task automatic t_febe();
      febe_ind = 1;
      run(FRAME);
      febe_ind = 0;
   endtask

   task automatic t_m23();
      cbp_mode = 0; stuff_ind = 7'b1010011;
      run(FRAME);
      stuff_ind = 7'b0101100;
      run(FRAME);
      cbp_mode = 1;
   endtask

   task automatic t_force();
      fdev = 0;
      run(100);
      force_f = 1; force_m = 1; force_p = 1; force_cp = 1; force_febe = 1;
      run(3000);
      force_f = 0; force_m = 0; force_p = 0; force_cp = 0; force_febe = 0;
      run(2 * FRAME - 3100);
      nchk++;
      if (fdev != 1) begin
         errors++;
         $display("FAIL R11 held force: inverted F-bits actual=%0d expected=1", fdev);
      end
      force_p = 1; run(5); force_p = 0;
      run(FRAME);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, nchk);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      t_reset();
      t_cbp();
      t_febe();
      t_m23();
      t_force();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, nchk);
      $finish;
   end

endmodule